// File: doc/BRIEF.md
# Flash Status-Poll Completion Checker

This block sits on the controller side of a parallel flash and decides when a program or erase operation has finished. It does so by reading the device's status byte again and again, not by watching a ready pin. Once the command sequence has gone out, the host starts the checker. The start request carries:

- the operation type,
- the address to poll,
- the data that was programmed,
- the largest number of busy polls it will accept.

The checker then issues single reads on a simple request/acknowledge memory port, always at the latched address. A read whose completion bit matches the expected value ends the polling, but that read's low bits may not yet have settled. For that reason one more read is made, and its whole byte is compared with the expected value to give pass or fail. A set error bit during busy polling leads to one re-read of the completion bit before failure is reported. This is because the device may have finished in the same instant the error bit rose. Reaching the poll limit gives a timeout. Each result ends with a one-cycle done pulse, and the block returns to idle.

Top module: `flashPollChecker`

## Requirements
- R1: After reset, startReady is 1, done is 0, and memReq is 0. No read is issued until a start is accepted, and memReq is never high while startReady is high.
- R2: A startReq while startReady is high latches the request, and memReq rises in the next cycle. Each read holds memReq high, with memAddr equal to the latched startAddr, until a cycle with memAck = 1. memRdata is taken in that same cycle. Every read of one operation uses the same address.
- R3: For startOp = 0 (program), a poll read whose bit 7 equals bit 7 of startData counts as true. A poll read whose bit 7 is the complement counts as busy and is followed by another poll read.
- R4: For startOp = 1 (erase), the expected byte is all ones, so a poll read with bit 7 = 1 is true and one with bit 7 = 0 is busy.
- R5: After a true poll read, exactly one confirming read is made. pass is then 1 if and only if that read's full byte equals the expected byte (startData for program, 8'hFF for erase), and timeout is 0.
- R6: A busy poll read with bit 5 = 1 is followed by exactly one re-read. If that re-read is still busy on bit 7, the result is fail (pass = 0, timeout = 0) and no further read follows. Bit 5 takes precedence over the poll limit.
- R7: If the re-read after a bit-5 event shows bit 7 true, a confirming read follows and the result is decided as in R5.
- R8: With maxPolls = N (N ≥ 1), the N-th busy poll read without bit 5 ends the operation with timeout = 1 and pass = 0. Exactly N reads are made in that case.
- R9: done is a single-cycle pulse in the cycle after the final memAck, and startReady is 1 in that cycle. pass and timeout keep their values until the next start is accepted.
- R10: startReq while startReady is 0 is ignored. It does not change the polled address and does not start a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a polling sequence (taken when startReady is 1) |
| startOp | input | 1 | 0 = program, 1 = erase |
| startAddr | input | ADDR_W | Address to poll |
| startData | input | DATA_W | Programmed data (program only) |
| maxPolls | input | CNT_W | Busy poll limit, at least 1 |
| startReady | output | 1 | Idle and able to accept a start |
| memReq | output | 1 | Read request, held until acknowledged |
| memAddr | output | ADDR_W | Read address |
| memAck | input | 1 | Read completes in this cycle |
| memRdata | input | DATA_W | Read data, valid with memAck |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Confirming read matched the expected byte |
| timeout | output | 1 | Poll limit reached |

## Verification
The flash side is modelled as a scripted sequence of status bytes. The scripts cover several cases: a number of complement reads followed by a true read with unsettled low bits; a bit-5 event on the last busy read, which the re-read must clear; a bit-5 event while the device stays busy; and runs longer than the poll limit. A confirming byte that differs in one low bit shows whether the full-byte comparison is really made, and not a bit-7-only check. The read count in each case separates timeout, fail after re-read, and pass/fail after confirm. Random operation types, data and limits mix program and erase polarity. A directed start pulse during a busy sequence shows whether a start is wrongly taken mid-operation.

// File: rtl/pollPkg.sv
package pollPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHECK,
    ST_CONFIRM
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic countInc;
    logic finishPass;
    logic finishFail;
    logic finishTimeout;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic trueBit7;
    logic failBit5;
    logic lastPoll;
    logic fullMatch;
  } pathFlags_t;

endpackage

// File: rtl/pollPath.sv
module pollPath
  import pollPkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16,
  parameter int DONE_BIT = 7,
  parameter int FAIL_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              startOp,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic [CNT_W-1:0]  maxPolls,
  input  logic [DATA_W-1:0] memRdata,
  output pathFlags_t        flags,
  output logic [ADDR_W-1:0] memAddr,
  output logic              done,
  output logic              pass,
  output logic              timeout
);

  localparam int WIDE_W = CNT_W + 1;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] expQ;
  logic [CNT_W-1:0]  limitQ;
  logic [CNT_W-1:0]  countQ;
  logic              doneQ, passQ, timeoutQ;
  logic [WIDE_W-1:0] nextCount;

  assign nextCount = {1'b0, countQ} + WIDE_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      expQ     <= '0;
      limitQ   <= '0;
      countQ   <= '0;
      doneQ    <= 1'b0;
      passQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      if (strobe.latch) begin
        addrQ    <= startAddr;
        expQ     <= startOp ? '1 : startData;
        limitQ   <= maxPolls;
        countQ   <= '0;
        passQ    <= 1'b0;
        timeoutQ <= 1'b0;
      end
      if (strobe.countInc) countQ <= nextCount[CNT_W-1:0];
      if (strobe.finishPass) passQ <= 1'b1;
      if (strobe.finishTimeout) timeoutQ <= 1'b1;
      doneQ <= strobe.finishPass | strobe.finishFail | strobe.finishTimeout;
    end
  end

  assign flags.trueBit7  = (memRdata[DONE_BIT] == expQ[DONE_BIT]);
  assign flags.failBit5  = memRdata[FAIL_BIT];
  assign flags.lastPoll  = (nextCount >= {1'b0, limitQ});
  assign flags.fullMatch = (memRdata == expQ);

  assign memAddr = addrQ;
  assign done    = doneQ;
  assign pass    = passQ;
  assign timeout = timeoutQ;

endmodule

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        memAck,
  input  pathFlags_t  flags,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        startReady
);

  pollState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          strobe.latch = 1'b1;
          stateD       = ST_POLL;
        end
      end
      ST_POLL: begin
        if (memAck) begin
          strobe.countInc = 1'b1;
          if (flags.trueBit7) begin
            stateD = ST_CONFIRM;
          end else if (flags.failBit5) begin
            stateD = ST_RECHECK;
          end else if (flags.lastPoll) begin
            strobe.finishTimeout = 1'b1;
            stateD               = ST_IDLE;
          end
        end
      end
      ST_RECHECK: begin
        if (memAck) begin
          if (flags.trueBit7) begin
            stateD = ST_CONFIRM;
          end else begin
            strobe.finishFail = 1'b1;
            stateD            = ST_IDLE;
          end
        end
      end
      ST_CONFIRM: begin
        if (memAck) begin
          strobe.finishPass = flags.fullMatch;
          strobe.finishFail = !flags.fullMatch;
          stateD            = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign memReq     = (stateQ != ST_IDLE);
  assign startReady = (stateQ == ST_IDLE);

endmodule

// File: rtl/flashPollChecker.sv
module flashPollChecker
  import pollPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              startOp,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic [CNT_W-1:0]  maxPolls,
  output logic              startReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic              pass,
  output logic              timeout
);

  ctrlStrobe_t strobe;
  pathFlags_t  flags;

  pollCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .memAck    (memAck),
    .flags     (flags),
    .strobe    (strobe),
    .memReq    (memReq),
    .startReady(startReady)
  );

  pollPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startOp  (startOp),
    .startAddr(startAddr),
    .startData(startData),
    .maxPolls (maxPolls),
    .memRdata (memRdata),
    .flags    (flags),
    .memAddr  (memAddr),
    .done     (done),
    .pass     (pass),
    .timeout  (timeout)
  );

endmodule

// File: rtl/flashPollChecker_sva.sv
module flashPollChecker_sva #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              startReady,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done,
  input logic              pass,
  input logic              timeout
);

  assert_no_idle_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !startReady);

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startReady && startReq) |=> memReq);

  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> $stable(memAddr));

  assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && timeout));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (startReady && !memReq));

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

endmodule

bind flashPollChecker flashPollChecker_sva #(.ADDR_W(ADDR_W)) uSva (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .startReady(startReady),
  .memReq    (memReq),
  .memAck    (memAck),
  .memAddr   (memAddr),
  .done      (done),
  .pass      (pass),
  .timeout   (timeout)
);

// File: tb/flashPollChecker_test.sv
`timescale 1ns/1ps
module flashPollChecker_test;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic startOp = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [DATA_W-1:0] startData = '0;
  logic [CNT_W-1:0]  maxPolls = '0;
  logic startReady, memReq, done, pass, timeout;
  logic [ADDR_W-1:0] memAddr;
  logic memAck = 1'b0;
  logic [DATA_W-1:0] memRdata = '0;

  always #5 clk = ~clk;

  flashPollChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startOp(startOp),
    .startAddr(startAddr), .startData(startData), .maxPolls(maxPolls),
    .startReady(startReady), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memRdata(memRdata), .done(done), .pass(pass),
    .timeout(timeout)
  );

  int total = 0;
  int bad = 0;

  // scenario driven into the flash model
  logic [ADDR_W-1:0] sAddr;
  logic [7:0] sExp;
  logic [7:0] sFinal;
  int sBusy;
  int sB5;
  int readIdx = 0;
  int addrBad = 0;
  int ackWait = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] flashByte(input int i);
    logic [7:0] b;
    b = 8'($urandom);
    if (i < sBusy) begin
      b[7] = ~sExp[7];
      b[5] = (sB5 >= 0 && i >= sB5);
    end else if (i == sBusy) begin
      b[7] = sExp[7];
    end else begin
      b = sFinal;
    end
    return b;
  endfunction

  // flash read responder with random latency
  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0;
    end else if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (ackWait == 0) begin
        if (memAddr != sAddr) addrBad++;
        memRdata = flashByte(readIdx);
        readIdx++;
        memAck = 1'b1;
        ackWait = $urandom % 3;
      end else begin
        ackWait--;
      end
    end
  end

  // expected outcome: 0 pass, 1 fail, 2 timeout; also read count
  function automatic void expect_result(input int k, input int b5, input int n,
                                        input logic match, output int res, output int reads);
    if (b5 >= 0 && b5 < n) begin
      if (b5 < k - 1) begin res = 1; reads = b5 + 2; end
      else begin res = match ? 0 : 1; reads = k + 2; end
    end else if (k >= n) begin
      res = 2; reads = n;
    end else begin
      res = match ? 0 : 1; reads = k + 2;
    end
  endfunction

  task automatic runOp(input string req, input logic op, input logic [7:0] data,
                       input logic [ADDR_W-1:0] addr, input int k, input int b5,
                       input logic [7:0] fin, input int n, input logic poke);
    int res, reads, waitCnt;
    logic [7:0] e;
    e = op ? 8'hFF : data;
    sAddr = addr; sExp = e; sFinal = fin; sBusy = k; sB5 = b5;
    readIdx = 0; addrBad = 0;
    expect_result(k, b5, n, fin == e, res, reads);
    @(negedge clk);
    check(req, "startReady before start", int'(startReady), 1);
    startOp = op; startData = data; startAddr = addr; maxPolls = CNT_W'(n);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R2", "memReq after start", int'(memReq), 1);
    if (poke) begin
      startReq = 1'b1; startAddr = ~addr; startOp = ~op;
      @(negedge clk);
      @(negedge clk);
      startReq = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(req, "done seen", int'(done), 1);
    check(req, "pass", int'(pass), int'(res == 0));
    check(req, "timeout", int'(timeout), int'(res == 2));
    check(req, "read count", readIdx, reads);
    check("R2", "address mismatches", addrBad, 0);
    check("R9", "startReady with done", int'(startReady), 1);
    @(negedge clk);
    check("R9", "done one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    check("R9", "pass held", int'(pass), int'(res == 0));
    check(req, "no extra read after done", readIdx, reads);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R1", "startReady in reset", int'(startReady), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "startReady idle", int'(startReady), 1);
    check("R1", "memReq idle", int'(memReq), 0);
    check("R1", "done idle", int'(done), 0);

    // directed corners
    runOp("R3", 1'b0, 8'h5A, 20'h01234, 3, -1, 8'h5A, 8, 1'b0);  // program pass, bit7=0
    runOp("R3", 1'b0, 8'hC3, 20'h00010, 0, -1, 8'hC3, 1, 1'b0);  // true on first read
    runOp("R4", 1'b1, 8'h00, 20'h40000, 4, -1, 8'hFF, 9, 1'b0);  // erase pass
    runOp("R5", 1'b1, 8'h00, 20'h40001, 2, -1, 8'hEF, 9, 1'b0);  // erase bad confirm
    runOp("R5", 1'b0, 8'h80, 20'h00200, 1, -1, 8'h81, 5, 1'b0);  // low-bit mismatch
    runOp("R6", 1'b0, 8'h11, 20'h00300, 100, 2, 8'h11, 10, 1'b0); // bit5 stays busy
    runOp("R6", 1'b0, 8'h22, 20'h00301, 100, 3, 8'h22, 4, 1'b0);  // bit5 on last allowed poll
    runOp("R7", 1'b1, 8'h00, 20'h00400, 3, 2, 8'hFF, 6, 1'b0);    // bit5 then complete
    runOp("R8", 1'b0, 8'h7E, 20'h00500, 5, -1, 8'h7E, 5, 1'b0);   // timeout at limit
    runOp("R8", 1'b1, 8'h00, 20'h00501, 1, -1, 8'hFF, 1, 1'b0);   // limit of one
    runOp("R10", 1'b0, 8'h3C, 20'h00600, 4, -1, 8'h3C, 8, 1'b1);  // start pulse while busy

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic op;
      logic [7:0] d, e, f;
      int k, n, b5;
      op = 1'($urandom);
      d = 8'($urandom);
      e = op ? 8'hFF : d;
      n = 1 + ($urandom % 6);
      k = ($urandom % 5 == 0) ? 50 : int'($urandom % 7);
      b5 = (k > 0 && $urandom % 3 == 0) ? int'($urandom % k) : -1;
      f = ($urandom % 4 == 0) ? (e ^ (8'h01 << ($urandom % 7))) : e;
      runOp(op ? "R4" : "R3", op, d, ADDR_W'($urandom), k, b5, f, n, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule